// File: doc/BRIEF.md
# Exception Status and Cause Unit

This unit keeps the privileged control state that a simple processor needs to take and return from exceptions and interrupts. It holds three registers. The status register carries a three-level stack of interrupt-enable and kernel/user pairs and a per-level interrupt mask. The cause register carries one pending bit per hardware interrupt line and the code of the last exception. The exception-return register holds the address of the interrupted instruction.

The pipeline signals an exception entry with a code and the faulting PC. The unit then pushes the mode stack, which enters kernel mode with interrupts off, and reports the fixed handler vector. A return strobe pops the stack. Hardware interrupt lines set sticky pending bits whether or not they are masked. The unit raises an interrupt request when the global enable is on and an unmasked level is pending. Software reads and writes the registers through a small select/data port. Writes are honoured only in kernel mode.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After reset the status, cause and exception-return registers read 0, `kern_mode` is 1 and `irq_req` is 0.
- R2: The status register reads the current pair in bits [1:0], the previous pair in [3:2] and the old pair in [5:4]. In each pair the low bit is the interrupt enable (1 = on) and the high bit is the mode (1 = user). The mask is in bits [12:8] and all other bits read 0. `kern_mode` is the inverse of bit 1.
- R3: On `exc_take`, the stack moves up by one pair (current to previous, previous to old) and the current pair becomes 00. The next cycle is therefore in kernel mode with interrupts off.
- R4: On `rfe` without `exc_take`, previous moves to current and old moves to previous, and the old pair keeps its value.
- R5: `irq_req` is 1 exactly when status bit 0 is 1 and some level has both its pending bit and its mask bit set.
- R6: Pending bit i (cause bit 8+i) is set in the cycle after `hw_irq[i]` is high, whatever the mask. It stays set until `irq_ack[i]` is high while `hw_irq[i]` is low. A high line wins over an acknowledge in the same cycle.
- R7: Writes to the cause register leave the pending field unchanged and load only the code field, bits [6:2].
- R8: `exc_take` loads `exc_pc` into the exception-return register and `exc_code` into cause bits [6:2].
- R9: `vec_addr` always equals 0x80000080.
- R10: A register write (`reg_sel` 0 = status, 1 = cause, 2 = exception return, 3 = reads 0) takes effect at the next edge only while `kern_mode` is 1. In user mode it is ignored.
- R11: `exc_take` takes priority over `rfe`, and `rfe` takes priority over a register write in the same cycle. A register write in a cycle with either strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_take | input | 1 | Exception or interrupt entry strobe |
| exc_code | input | 5 | Exception type for the cause register |
| exc_pc | input | 32 | Address of the interrupted instruction |
| hw_irq | input | 5 | Hardware interrupt lines, one per level |
| irq_ack | input | 5 | Per-level pending-bit acknowledge |
| rfe | input | 1 | Return-from-exception strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_req | output | 1 | Interrupt request to the pipeline |
| kern_mode | output | 1 | 1 when in kernel mode |
| vec_addr | output | 32 | Handler entry address |

## Verification
The hardest state to reach from the ports is a deep, mixed stack. This is a user-mode current pair with distinct values in all three levels, followed by a pop that must duplicate the old pair. User mode is reachable only through a kernel-mode status write or a pop that lands on a user pair. A directed sequence therefore first writes a user pair in kernel mode, then nests two entries, then pops twice. It then fires entry, return and a status write together. A long random phase with frequent entries, returns and writes then wanders through the other stack contents. There, rejected user-mode writes and set-versus-acknowledge collisions on the pending bits occur many times.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int STK_W    = 6;
  localparam int MASK_LSB = 8;
  localparam int PEND_LSB = 8;
  localparam int CODE_LSB = 2;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CAUSE  = 2'd1,
    SEL_EPC    = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  // entry: every pair moves one level up, current becomes kernel / disabled
  function automatic logic [STK_W-1:0] stk_push(logic [STK_W-1:0] s);
    return {s[3:0], 2'b00};
  endfunction

  // return: every pair moves one level down, the top pair is duplicated
  function automatic logic [STK_W-1:0] stk_pop(logic [STK_W-1:0] s);
    return {s[5:4], s[5:2]};
  endfunction
endpackage

// File: rtl/exc_mode_stack.sv
module exc_mode_stack
  import exc_pkg::*;
#(
  parameter int N_IRQ = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             wr_en,
  input  logic [STK_W-1:0] wr_stack,
  input  logic [N_IRQ-1:0] wr_mask,
  output logic [STK_W-1:0] stack,
  output logic [N_IRQ-1:0] mask
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stack <= '0;
      mask  <= '0;
    end else if (push) begin
      stack <= stk_push(stack);
    end else if (pop) begin
      stack <= stk_pop(stack);
    end else if (wr_en) begin
      stack <= wr_stack;
      mask  <= wr_mask;
    end
  end
endmodule

// File: rtl/exc_pend_latch.sv
module exc_pend_latch #(
  parameter int N_IRQ = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] hw_irq,
  input  logic [N_IRQ-1:0] irq_ack,
  output logic [N_IRQ-1:0] pend
);
  for (genvar i = 0; i < N_IRQ; i++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (!rst_n)          pend[i] <= 1'b0;
      else if (hw_irq[i])  pend[i] <= 1'b1;
      else if (irq_ack[i]) pend[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/exc_cause_epc.sv
module exc_cause_epc #(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [CODE_W-1:0] code_in,
  input  logic [XLEN-1:0]   pc_in,
  input  logic              wr_code,
  input  logic [CODE_W-1:0] code_wdata,
  input  logic              wr_epc,
  input  logic [XLEN-1:0]   epc_wdata,
  output logic [CODE_W-1:0] code,
  output logic [XLEN-1:0]   epc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code <= '0;
      epc  <= '0;
    end else if (capture) begin
      code <= code_in;
      epc  <= pc_in;
    end else begin
      if (wr_code) code <= code_wdata;
      if (wr_epc)  epc  <= epc_wdata;
    end
  end
endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
  import exc_pkg::*;
#(
  parameter int          N_IRQ    = 5,
  parameter int          XLEN     = 32,
  parameter int          CODE_W   = 5,
  parameter logic [31:0] VEC_ADDR = 32'h8000_0080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_take,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   exc_pc,
  input  logic [N_IRQ-1:0]  hw_irq,
  input  logic [N_IRQ-1:0]  irq_ack,
  input  logic              rfe,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [XLEN-1:0]   reg_wdata,
  output logic [XLEN-1:0]   reg_rdata,
  output logic              irq_req,
  output logic              kern_mode,
  output logic [XLEN-1:0]   vec_addr
);
  function automatic logic irq_eval(logic ie, logic [N_IRQ-1:0] msk,
                                    logic [N_IRQ-1:0] pnd);
    return ie & (|(msk & pnd));
  endfunction

  logic [STK_W-1:0]  stack;
  logic [N_IRQ-1:0]  mask;
  logic [N_IRQ-1:0]  pend;
  logic [CODE_W-1:0] code;
  logic [XLEN-1:0]   epc;

  // named internal events
  logic cur_ie, cur_ku;
  logic evt_push, evt_pop, evt_wr_ok;
  logic evt_wr_status, evt_wr_cause, evt_wr_epc;
  reg_sel_e sel;

  assign sel           = reg_sel_e'(reg_sel);
  assign cur_ie        = stack[0];
  assign cur_ku        = stack[1];
  assign evt_push      = exc_take;
  assign evt_pop       = rfe & ~exc_take;
  assign evt_wr_ok     = reg_wr & ~cur_ku & ~exc_take & ~rfe;
  assign evt_wr_status = evt_wr_ok & (sel == SEL_STATUS);
  assign evt_wr_cause  = evt_wr_ok & (sel == SEL_CAUSE);
  assign evt_wr_epc    = evt_wr_ok & (sel == SEL_EPC);

  exc_mode_stack #(.N_IRQ(N_IRQ)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (evt_push),
    .pop      (evt_pop),
    .wr_en    (evt_wr_status),
    .wr_stack (reg_wdata[STK_W-1:0]),
    .wr_mask  (reg_wdata[MASK_LSB +: N_IRQ]),
    .stack    (stack),
    .mask     (mask)
  );

  exc_pend_latch #(.N_IRQ(N_IRQ)) u_pend (
    .clk     (clk),
    .rst_n   (rst_n),
    .hw_irq  (hw_irq),
    .irq_ack (irq_ack),
    .pend    (pend)
  );

  exc_cause_epc #(.XLEN(XLEN), .CODE_W(CODE_W)) u_cause (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (evt_push),
    .code_in    (exc_code),
    .pc_in      (exc_pc),
    .wr_code    (evt_wr_cause),
    .code_wdata (reg_wdata[CODE_LSB +: CODE_W]),
    .wr_epc     (evt_wr_epc),
    .epc_wdata  (reg_wdata),
    .code       (code),
    .epc        (epc)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_STATUS: begin
        reg_rdata[STK_W-1:0]         = stack;
        reg_rdata[MASK_LSB +: N_IRQ] = mask;
      end
      SEL_CAUSE: begin
        reg_rdata[PEND_LSB +: N_IRQ]  = pend;
        reg_rdata[CODE_LSB +: CODE_W] = code;
      end
      SEL_EPC:  reg_rdata = epc;
      default:  reg_rdata = '0;
    endcase
  end

  assign irq_req   = irq_eval(cur_ie, mask, pend);
  assign kern_mode = ~cur_ku;
  assign vec_addr  = XLEN'(VEC_ADDR);
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter int N_IRQ = 5,
  parameter int XLEN  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             exc_take,
  input logic             rfe,
  input logic [XLEN-1:0]  exc_pc,
  input logic [N_IRQ-1:0] hw_irq,
  input logic [N_IRQ-1:0] irq_ack,
  input logic             reg_wr,
  input logic [1:0]       reg_sel,
  input logic             irq_req,
  input logic             kern_mode,
  input logic [5:0]       stack,
  input logic [N_IRQ-1:0] mask,
  input logic [N_IRQ-1:0] pend,
  input logic [XLEN-1:0]  epc
);
  AST_ENTRY_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> stack == {$past(stack[3:0]), 2'b00}); // R3

  AST_ENTRY_KERNEL: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> (kern_mode && !irq_req)); // R3

  AST_RETURN_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe && !exc_take) |=> (stack[1:0] == $past(stack[3:2]) &&
                            stack[3:2] == $past(stack[5:4]) &&
                            stack[5:4] == $past(stack[5:4]))); // R4

  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    !stack[0] |-> !irq_req); // R5

  AST_PEND_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_irq != '0) |=> ((pend & $past(hw_irq)) == $past(hw_irq))); // R6

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend) & ~$past(irq_ack)) & ~pend) == '0)); // R6

  AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> epc == $past(exc_pc)); // R8

  AST_USER_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd0 && !kern_mode && !exc_take && !rfe)
      |=> ($stable(stack) && $stable(mask))); // R10
endmodule

bind exc_ctrl_unit exc_ctrl_chk #(.N_IRQ(N_IRQ), .XLEN(XLEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .exc_take  (exc_take),
  .rfe       (rfe),
  .exc_pc    (exc_pc),
  .hw_irq    (hw_irq),
  .irq_ack   (irq_ack),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .irq_req   (irq_req),
  .kern_mode (kern_mode),
  .stack     (stack),
  .mask      (mask),
  .pend      (pend),
  .epc       (epc)
);

// File: tb/sim_exc_ctrl_unit.sv
`timescale 1ns/1ps
module sim_exc_ctrl_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_take = 1'b0;
  logic [4:0]  exc_code = '0;
  logic [31:0] exc_pc = '0;
  logic [4:0]  hw_irq = '0;
  logic [4:0]  irq_ack = '0;
  logic        rfe = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_req, kern_mode;
  logic [31:0] vec_addr;

  always #2.5 clk = ~clk;

  exc_ctrl_unit u0 (
    .clk(clk), .rst_n(rst_n), .exc_take(exc_take), .exc_code(exc_code),
    .exc_pc(exc_pc), .hw_irq(hw_irq), .irq_ack(irq_ack), .rfe(rfe),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req), .kern_mode(kern_mode),
    .vec_addr(vec_addr)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model, kept as separate pairs: lvl[0] current, lvl[1] previous, lvl[2] old
  logic [1:0]  lvl [3];
  logic [4:0]  m_mask, m_pend, m_code;
  logic [31:0] m_epc;

  function automatic logic [31:0] m_status();
    return {19'd0, m_mask, 2'b00, lvl[2], lvl[1], lvl[0]};
  endfunction

  function automatic logic [31:0] m_read(logic [1:0] s);
    case (s)
      2'd0:    return m_status();
      2'd1:    return (32'(m_pend) << 8) | (32'(m_code) << 2);
      2'd2:    return m_epc;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic m_irq();
    logic any = 1'b0;
    for (int i = 0; i < 5; i++) if (m_pend[i] && m_mask[i]) any = 1'b1;
    return lvl[0][0] && any;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic user = lvl[0][1];
    for (int i = 0; i < 5; i++)
      if (hw_irq[i]) m_pend[i] = 1'b1;
      else if (irq_ack[i]) m_pend[i] = 1'b0;
    if (exc_take) begin
      lvl[2] = lvl[1]; lvl[1] = lvl[0]; lvl[0] = 2'b00;
      m_code = exc_code; m_epc = exc_pc;
    end else if (rfe) begin
      lvl[0] = lvl[1]; lvl[1] = lvl[2];
    end else if (reg_wr && !user) begin
      case (reg_sel)
        2'd0: begin
          lvl[0] = reg_wdata[1:0]; lvl[1] = reg_wdata[3:2];
          lvl[2] = reg_wdata[5:4]; m_mask = reg_wdata[12:8];
        end
        2'd1: m_code = reg_wdata[6:2];
        2'd2: m_epc = reg_wdata;
        default: ;
      endcase
    end
  endtask

  // called just after a negedge with inputs applied; ends after the next negedge
  task automatic cycle();
    string rtag;
    #0.5;
    rtag = (reg_sel == 2'd1) ? "R6 cause read" :
           (reg_sel == 2'd2) ? "R8 epc read" : "R2 status read";
    chk(rtag, reg_rdata, m_read(reg_sel));
    chk("R5 irq_req", 32'(irq_req), 32'(m_irq()));
    chk("R2 kern_mode", 32'(kern_mode), 32'(!lvl[0][1]));
    chk("R9 vec_addr", vec_addr, 32'h8000_0080);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic quiet();
    exc_take = 0; rfe = 0; reg_wr = 0; hw_irq = '0; irq_ack = '0;
  endtask

  task automatic peek(string tag, logic [1:0] s, logic [31:0] exp);
    reg_sel = s; #0.5;
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    void'($urandom(32'h5EED_0C0D));
    lvl[0] = 0; lvl[1] = 0; lvl[2] = 0;
    m_mask = 0; m_pend = 0; m_code = 0; m_epc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    peek("R1 status", 2'd0, 32'h0);
    peek("R1 cause", 2'd1, 32'h0);
    peek("R1 epc", 2'd2, 32'h0);
    chk("R1 kern_mode", 32'(kern_mode), 32'd1);
    chk("R1 irq_req", 32'(irq_req), 32'd0);

    // R10 kernel write lands: IE=1, user, all levels unmasked
    quiet(); reg_wr = 1; reg_sel = 0; reg_wdata = 32'hFFFF_FF03 & 32'h0000_1F03;
    cycle(); quiet();
    peek("R10 kernel write", 2'd0, 32'h0000_1F03);
    chk("R2 user mode flag", 32'(kern_mode), 32'd0);
    // R10 user write ignored
    reg_wr = 1; reg_sel = 0; reg_wdata = 32'h0; cycle(); quiet();
    peek("R10 user write ignored", 2'd0, 32'h0000_1F03);
    reg_wr = 1; reg_sel = 2; reg_wdata = 32'hDEAD_BEEF; cycle(); quiet();
    peek("R10 user epc write ignored", 2'd2, 32'h0);

    // R6 pending sets, R5 request
    hw_irq = 5'b00100; cycle(); quiet();
    peek("R6 pending set", 2'd1, 32'h0000_0400);
    chk("R5 irq_req raised", 32'(irq_req), 32'd1);

    // R3 / R8 first entry
    exc_take = 1; exc_code = 5'd8; exc_pc = 32'h0000_1234; cycle(); quiet();
    peek("R3 push once", 2'd0, 32'h0000_1F0C);
    chk("R3 kernel after entry", 32'(kern_mode), 32'd1);
    chk("R3 irq off after entry", 32'(irq_req), 32'd0);
    peek("R8 epc capture", 2'd2, 32'h0000_1234);
    peek("R8 code capture", 2'd1, 32'h0000_0420);

    // R7 cause write keeps pending
    reg_wr = 1; reg_sel = 1; reg_wdata = 32'hFFFF_FFFF; cycle(); quiet();
    peek("R7 pending untouched", 2'd1, 32'h0000_047C);

    // nested entry then two returns
    exc_take = 1; exc_code = 5'd3; exc_pc = 32'h0000_2000; cycle(); quiet();
    peek("R3 push twice", 2'd0, 32'h0000_1F30);
    rfe = 1; cycle(); quiet();
    peek("R4 pop once", 2'd0, 32'h0000_1F3C);
    rfe = 1; cycle(); quiet();
    peek("R4 pop duplicates old", 2'd0, 32'h0000_1F3F);
    chk("R5 irq after return", 32'(irq_req), 32'd1);

    // R11 entry + return + write together
    exc_take = 1; rfe = 1; reg_wr = 1; reg_sel = 0; reg_wdata = 32'h0;
    exc_code = 5'd1; exc_pc = 32'h0000_0040; cycle(); quiet();
    peek("R11 entry wins", 2'd0, 32'h0000_1F3C);
    peek("R11 epc from entry", 2'd2, 32'h0000_0040);
    rfe = 1; reg_wr = 1; reg_sel = 2; reg_wdata = 32'h5555_5555; cycle(); quiet();
    peek("R11 write dropped under return", 2'd2, 32'h0000_0040);

    // R6 acknowledge and collision
    irq_ack = 5'b00100; cycle(); quiet();
    peek("R6 ack clears", 2'd1, 32'h0000_0004);
    hw_irq = 5'b00010; irq_ack = 5'b00010; cycle(); quiet();
    peek("R6 set wins over ack", 2'd1, 32'h0000_0204);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(0, 99));
      quiet();
      exc_take  = (r < 10);
      rfe       = (r >= 10 && r < 22) || ($urandom_range(0, 19) == 0);
      reg_wr    = ($urandom_range(0, 9) < 3);
      reg_sel   = 2'($urandom_range(0, 3));
      reg_wdata = $urandom();
      exc_code  = 5'($urandom());
      exc_pc    = $urandom();
      hw_irq    = ($urandom_range(0, 3) == 0) ? 5'($urandom()) & 5'($urandom()) : 5'd0;
      irq_ack   = 5'($urandom());
      cycle();
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule